// File: doc/BRIEF.md
# Word-Wide FIFO Packer with Transfer Length Counter

This block sits between a 32-bit data port and the byte-wide transmit and receive FIFOs of a serial peripheral controller. A serial shifter consumes transmit bytes and delivers receive bytes; it is outside this block. In wide mode every data-port write deposits up to four bytes into the transmit FIFO, and every read removes up to four bytes from the receive FIFO. A programmable 16-bit transfer length sets how many bytes the transfer carries. It also sets how many bytes the last word access actually moves. In narrow mode each access moves a single byte.

The length register also drives a completion flag and two request outputs for a memory-transfer engine. In wide mode the serial side runs bytes back to back. The length counter falls by one for each byte the shifter takes. Changing the access width discards the contents of both FIFOs, so no half-packed word survives a width change.

Top module: `spi_word_packer`

## Requirements
- R1: After reset both FIFOs are empty and the length is zero: `done`=1, `tx_req`=0, `rx_req`=0, `tx_byte_valid`=0.
- R2: In wide mode a write places `wr_data[7:0]` first in the transmit stream, then bits 15:8, 23:16 and 31:24 (little-endian).
- R3: A wide write moves min(4, bytes of the transfer not yet written) bytes. Bytes beyond that count are discarded. Once all transfer bytes have been written, further writes push nothing.
- R4: In wide mode the length counter falls by one per byte taken by the shifter. `tx_byte_valid` stays low while the counter is zero. `done` is 1 exactly when the counter is zero and the transmit FIFO is empty.
- R5: A wide read pops min(4, bytes of the transfer not yet read) bytes, returned little-endian in `rd_data`, with unused upper bytes zero.
- R6: In narrow mode a write pushes only `wr_data[7:0]`. A read pops one byte, returned in `rd_data[7:0]` with bits 31:8 zero.
- R7: A change of `wide_mode` empties both FIFOs in the cycle it is seen. Data pushed before the change never appears afterwards.
- R8: Loading length 0 together with `clr_fifos` returns the block to idle: `done`=1, `tx_req`=0, `rx_req`=0, `tx_byte_valid`=0.
- R9: `tx_req` is 1 only in wide mode, while transfer bytes remain to be written and at least 4 transmit FIFO bytes are free.
- R10: `rx_req` is 1 only in wide mode, while transfer bytes remain to be read and the receive FIFO holds at least min(4, bytes left to read).
- R11: A write whose bytes do not all fit in the transmit FIFO is dropped as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1: 32-bit accesses; 0: 8-bit accesses |
| clr_fifos | input | 1 | Empty both FIFOs this cycle |
| len_wr | input | 1 | Load the transfer length |
| len_wdata | input | 16 | Transfer length in bytes |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | 32 | Data-port write value |
| rd_en | input | 1 | Data-port read strobe (pops on the clock edge) |
| rd_data | output | 32 | Receive word at the FIFO head, masked to the bytes a read would pop |
| tx_byte | output | 8 | Next transmit byte for the shifter |
| tx_byte_valid | output | 1 | A transmit byte may be taken |
| tx_byte_take | input | 1 | Shifter takes the transmit byte |
| rx_byte | input | 8 | Byte received by the shifter |
| rx_byte_push | input | 1 | Store `rx_byte` in the receive FIFO |
| tx_req | output | 1 | Transmit word request |
| rx_req | output | 1 | Receive word request |
| done | output | 1 | Length exhausted and transmit FIFO empty |

## Verification
A read or write pointer that drifts by one lane shows up on the next transmit byte the shifter takes, or in the next word read: the bytes arrive rotated or repeated. A remaining-byte count that is off by one changes the lane count of the final access. That appears as a stray or missing byte in the stream and as `done` rising one byte early or late. A missed flush on a width change leaves stale bytes that lead the next stream in the very first access after the change.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;

    // Number of byte lanes an access may move given the bytes still left.
    function automatic logic [2:0] lane_cnt(input logic [31:0] left);
        return (left >= 32'(LANES)) ? 3'(LANES) : left[2:0];
    endfunction
endpackage

// File: rtl/pack_fifo.sv
module pack_fifo #(
    parameter int DEPTH      = 16,
    parameter int PUSH_LANES = 4,
    parameter int HEAD_LANES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [2:0]              push_n,
    input  logic [8*PUSH_LANES-1:0] push_data,
    input  logic [2:0]              pop_n,
    output logic [8*HEAD_LANES-1:0] head_data,
    output logic [CW-1:0]           count
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            for (int i = 0; i < PUSH_LANES; i++) begin
                if (3'(i) < push_n)
                    st_d.mem[st_q.wp + AW'(i)] = push_data[8*i +: 8];
            end
            st_d.wp  = st_q.wp + AW'(push_n);
            st_d.rp  = st_q.rp + AW'(pop_n);
            st_d.cnt = st_q.cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < HEAD_LANES; g++) begin : g_head
        assign head_data[8*g +: 8] = st_q.mem[st_q.rp + AW'(g)];
    end

    assign count = st_q.cnt;

    AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (CW'(push_n) <= CW'(DEPTH) - st_q.cnt)) else $error("push overflow"); // R11
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (CW'(pop_n) <= st_q.cnt)) else $error("pop underflow"); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)) else $error("flush left data"); // R7
endmodule

// File: rtl/len_ctrl.sv
module len_ctrl
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic             byte_shift,
    input  logic [2:0]       wr_dec,
    input  logic [2:0]       rd_dec,
    output logic [2:0]       wr_lanes,
    output logic [2:0]       rd_lanes,
    output logic             wr_more,
    output logic             rd_more,
    output logic             len_zero
);
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] wr_left;
        logic [LEN_W-1:0] rd_left;
    } len_st_t;

    len_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (len_wr) begin
            st_d.len     = len_wdata;
            st_d.wr_left = len_wdata;
            st_d.rd_left = len_wdata;
        end else if (wide) begin
            st_d.len     = st_q.len - LEN_W'(byte_shift);
            st_d.wr_left = st_q.wr_left - LEN_W'(wr_dec);
            st_d.rd_left = st_q.rd_left - LEN_W'(rd_dec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_lanes = lane_cnt(32'(st_q.wr_left));
    assign rd_lanes = lane_cnt(32'(st_q.rd_left));
    assign wr_more  = (st_q.wr_left != '0);
    assign rd_more  = (st_q.rd_left != '0);
    assign len_zero = (st_q.len == '0);

    AST_NO_LEN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !len_wr && byte_shift) |-> !len_zero) else $error("length wrapped"); // R4
    AST_WR_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !len_wr) |-> (wr_dec <= wr_lanes)) else $error("write overrun"); // R3
    AST_RD_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !len_wr) |-> (rd_dec <= rd_lanes)) else $error("read overrun"); // R5
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
    import spi_pack_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_mode,
    input  logic             clr_fifos,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    output logic [31:0]      rd_data,
    output logic [7:0]       tx_byte,
    output logic             tx_byte_valid,
    input  logic             tx_byte_take,
    input  logic [7:0]       rx_byte,
    input  logic             rx_byte_push,
    output logic             tx_req,
    output logic             rx_req,
    output logic             done
);
    typedef struct packed {
        logic mode;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          flush;
    logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
    logic [2:0]    wr_lanes, rd_lanes, w_n, r_n;
    logic [2:0]    tx_push_n, rx_pop_n, tx_pop_n, rx_push_n;
    logic          wr_more, rd_more, len_zero, take;
    logic [31:0]   rx_head;

    always_comb begin
        st_d.mode     = wide_mode;
        flush         = clr_fifos || (wide_mode != st_q.mode);
        tx_free       = CW'(DEPTH) - tx_cnt;
        w_n           = wide_mode ? wr_lanes : 3'd1;
        r_n           = wide_mode ? rd_lanes : 3'd1;
        tx_push_n     = (wr_en && !flush && w_n != 3'd0 && CW'(w_n) <= tx_free) ? w_n : 3'd0;
        rx_pop_n      = (rd_en && !flush && r_n != 3'd0 && CW'(r_n) <= rx_cnt)  ? r_n : 3'd0;
        tx_byte_valid = !flush && (tx_cnt != '0) && (!wide_mode || !len_zero);
        take          = tx_byte_take && tx_byte_valid;
        tx_pop_n      = {2'b00, take};
        rx_push_n     = {2'b00, rx_byte_push && !flush && (rx_cnt < CW'(DEPTH))};
        for (int i = 0; i < LANES; i++)
            rd_data[8*i +: 8] = (3'(i) < r_n) ? rx_head[8*i +: 8] : 8'h00;
        tx_req = wide_mode && wr_more && (tx_free >= CW'(LANES));
        rx_req = wide_mode && rd_more && (rx_cnt >= CW'(rd_lanes));
        done   = len_zero && (tx_cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pack_fifo #(.DEPTH(DEPTH), .PUSH_LANES(LANES), .HEAD_LANES(1)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_n(tx_push_n), .push_data(wr_data),
        .pop_n(tx_pop_n), .head_data(tx_byte), .count(tx_cnt)
    );

    pack_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .HEAD_LANES(LANES)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_n(rx_push_n), .push_data(rx_byte),
        .pop_n(rx_pop_n), .head_data(rx_head), .count(rx_cnt)
    );

    len_ctrl #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .wide(wide_mode),
        .len_wr(len_wr), .len_wdata(len_wdata), .byte_shift(take),
        .wr_dec(tx_push_n), .rd_dec(rx_pop_n),
        .wr_lanes(wr_lanes), .rd_lanes(rd_lanes),
        .wr_more(wr_more), .rd_more(rd_more), .len_zero(len_zero)
    );

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_byte_valid) else $error("byte offered after done"); // R4
    AST_REQ_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req || rx_req) |-> wide_mode) else $error("request in narrow mode"); // R9
    AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fifos || wide_mode != st_q.mode) |=> !tx_byte_valid && !rx_req) else $error("flush incomplete"); // R7
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fifos && len_wr && len_wdata == '0) |=> done && !tx_req && !rx_req) else $error("not idle"); // R8
endmodule

// File: tb/spi_word_packer_bench.sv
module spi_word_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1, clr_fifos = 1'b0, len_wr = 1'b0;
    logic [15:0] len_wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, tx_byte_take = 1'b0, rx_byte_push = 1'b0;
    logic [31:0] wr_data = '0, rd_data;
    logic [7:0]  tx_byte, rx_byte = '0;
    logic        tx_byte_valid, tx_req, rx_req, done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_word_packer u_spi_word_packer (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .clr_fifos(clr_fifos),
        .len_wr(len_wr), .len_wdata(len_wdata), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tx_byte(tx_byte), .tx_byte_valid(tx_byte_valid),
        .tx_byte_take(tx_byte_take), .rx_byte(rx_byte), .rx_byte_push(rx_byte_push),
        .tx_req(tx_req), .rx_req(rx_req), .done(done)
    );

    // {length, first word, second word}
    localparam logic [79:0] VEC [4] = '{
        {16'd8, 32'h44332211, 32'h88776655},
        {16'd6, 32'hA3A2A1A0, 32'hB3B2B1B0},
        {16'd5, 32'hDEADBEEF, 32'h0BADF00D},
        {16'd3, 32'hC0FFEE01, 32'h12345678}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] n, input bit clr);
        @(negedge clk); len_wr = 1'b1; len_wdata = n; clr_fifos = clr;
        @(negedge clk); len_wr = 1'b0; clr_fifos = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_word(output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk); rx_byte_push = 1'b1; rx_byte = b;
        @(negedge clk); rx_byte_push = 1'b0;
    endtask

    task automatic take_byte(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(tx_byte_valid && tx_byte == exp, req, {23'd0, tx_byte_valid, tx_byte}, {24'd1, exp});
        tx_byte_take = 1'b1;
        @(negedge clk); tx_byte_take = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done && !tx_req && !rx_req && !tx_byte_valid, "R1 reset",
            {28'd0, done, tx_req, rx_req, tx_byte_valid}, 32'h8);

        // Table walk: wide-mode transmit packing, R2 / R3 / R4
        for (int v = 0; v < 4; v++) begin
            logic [15:0] n;
            logic [31:0] w0, w1;
            n = VEC[v][79:64]; w0 = VEC[v][63:32]; w1 = VEC[v][31:0];
            load(n, 1'b1);
            chk(!done, "R4 done low after load", {31'd0, done}, 32'd0);
            wr_word(w0);
            wr_word(w1);
            for (int k = 0; k < int'(n); k++) begin
                logic [31:0] src;
                src = (k < 4) ? w0 : w1;
                take_byte("R2 byte order", src[8*(k%4) +: 8]);
            end
            @(negedge clk);
            chk(!tx_byte_valid, "R3 no extra bytes", {31'd0, tx_byte_valid}, 32'd0);
            chk(done, "R4 done after last byte", {31'd0, done}, 32'd1);
        end

        // R10 / R5: wide receive with short final word
        load(16'd6, 1'b1);
        for (int k = 0; k < 3; k++) push_rx(8'h10 + 8'(k));
        @(negedge clk);
        chk(!rx_req, "R10 below four bytes", {31'd0, rx_req}, 32'd0);
        push_rx(8'h13);
        @(negedge clk);
        chk(rx_req, "R10 four bytes held", {31'd0, rx_req}, 32'd1);
        push_rx(8'h14); push_rx(8'h15);
        rd_word(w);
        chk(w == 32'h13121110, "R5 full word", w, 32'h13121110);
        @(negedge clk);
        chk(rx_req, "R10 tail available", {31'd0, rx_req}, 32'd1);
        rd_word(w);
        chk(w == 32'h00001514, "R5 zero fill", w, 32'h00001514);
        @(negedge clk);
        chk(!rx_req, "R10 all read", {31'd0, rx_req}, 32'd0);

        // R11 / R9: overfull write dropped
        load(16'd20, 1'b1);
        @(negedge clk);
        chk(tx_req, "R9 space and bytes left", {31'd0, tx_req}, 32'd1);
        for (int k = 0; k < 4; k++) wr_word(32'h03020100 + 32'h04040404 * k);
        @(negedge clk);
        chk(!tx_req, "R9 fifo full", {31'd0, tx_req}, 32'd0);
        wr_word(32'hEEEEEEEE);
        for (int k = 0; k < 16; k++) take_byte("R11 stream", 8'(k));
        @(negedge clk);
        chk(!tx_byte_valid, "R11 dropped write", {31'd0, tx_byte_valid}, 32'd0);
        chk(tx_req && !done, "R11 bytes still owed", {30'd0, tx_req, done}, 32'h2);
        wr_word(32'h13121110);
        for (int k = 0; k < 4; k++) take_byte("R11 final word", 8'h10 + 8'(k));
        @(negedge clk);
        chk(done, "R4 done after 20", {31'd0, done}, 32'd1);

        // R6: narrow mode
        @(negedge clk); wide_mode = 1'b0;
        wr_word(32'hAABBCC11);
        @(negedge clk);
        chk(!tx_req, "R9 no request narrow", {31'd0, tx_req}, 32'd0);
        take_byte("R6 low byte only", 8'h11);
        @(negedge clk);
        chk(!tx_byte_valid, "R6 single byte pushed", {31'd0, tx_byte_valid}, 32'd0);
        push_rx(8'h5A); push_rx(8'h3C);
        rd_word(w);
        chk(w == 32'h0000005A, "R6 narrow read", w, 32'h5A);
        rd_word(w);
        chk(w == 32'h0000003C, "R6 narrow read 2", w, 32'h3C);

        // R7: width change flushes
        push_rx(8'h77);
        wr_word(32'h00000099);
        @(negedge clk);
        chk(tx_byte_valid, "R7 byte queued", {31'd0, tx_byte_valid}, 32'd1);
        wide_mode = 1'b1;
        @(negedge clk);
        chk(!tx_byte_valid, "R7 tx flushed", {31'd0, tx_byte_valid}, 32'd0);
        load(16'd8, 1'b0);
        @(negedge clk);
        chk(!rx_req, "R7 rx flushed", {31'd0, rx_req}, 32'd0);
        for (int k = 0; k < 4; k++) push_rx(8'hC0 + 8'(k));
        rd_word(w);
        chk(w == 32'hC3C2C1C0, "R7 no stale rx", w, 32'hC3C2C1C0);
        wr_word(32'h61626364);
        take_byte("R7 no stale tx", 8'h64);

        // R8: clear to idle
        load(16'd0, 1'b1);
        @(negedge clk);
        chk(done && !tx_req && !rx_req && !tx_byte_valid, "R8 idle",
            {28'd0, done, tx_req, rx_req, tx_byte_valid}, 32'h8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule